// File: doc/BRIEF.md
# Cascaded Two-Stage Interrupt Controller

This block gathers interrupt requests from up to fifteen devices and hands them to a processor over one interrupt line and a pulse acknowledge. Inside it are two eight-input resolver stages. The secondary stage serves request numbers 8 to 15. Its combined request occupies position 2 of the primary stage, and the primary stage serves numbers 0 to 7. Because position 2 is taken by the cascade, a device wired to request line 2 is folded onto line 9. Request number 2 is therefore never reported.

Each request pin passes through a two-flop synchroniser. A rising edge on it is kept in a pending bit, so a pulse only one clock long is not lost. Priority is fixed. From highest to lowest the order is 0, 1, 8 to 15, then 3 to 7. The processor acknowledges with a one-cycle pulse. One cycle later the block presents the 4-bit number of the winning line together with a valid strobe. At the same time that line moves from pending to in service.

While a line is in service, only lines of strictly higher priority can raise the interrupt again. An end-of-interrupt pulse carrying a line number takes that line out of service. If no line is eligible when the acknowledge arrives, the block reports code 7 as a spurious interrupt.

A small control FSM drives the processor-facing signals. Its states are:

- S_IDLE: no eligible request.
- S_PEND: interrupt asserted.
- S_REPORT: vector valid.

Its transitions are:

- S_IDLE to S_PEND when an eligible request exists.
- S_IDLE or S_PEND to S_REPORT on an acknowledge.
- S_PEND to S_IDLE when no eligible request remains.
- S_REPORT to S_REPORT on a fresh acknowledge.
- S_REPORT to S_PEND or S_IDLE, depending on whether an eligible request remains.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: During and right after reset, irq_out and vec_valid are low, and no line is pending or in service. An acknowledge then reports code 7.
- R2: A low-to-high transition on a request pin is latched as pending, even if the pin drops again after one cycle. irq_out rises after the fourth rising clock edge that follows the change. A pin that is held high does not latch a second request.
- R3: A rising edge on request pin 2 is latched as line 9 and reported as 9. vec_num never shows 2 while vec_valid is high.
- R4: Lines 0, 1 and 8 always report their own numbers, 0, 1 and 8.
- R5: When several lines are pending, the acknowledge selects by the fixed order 0, 1, 8, 9, 10, 11, 12, 13, 14, 15, 3, 4, 5, 6, 7.
- R6: After the clock edge on which ack is sampled high, vec_valid is high for exactly one cycle and vec_num holds the chosen number. irq_out is low in that cycle, and vec_num keeps its value until the next acknowledge.
- R7: An acknowledged line leaves the pending state and enters the in-service state. It is not reported again without a new rising edge.
- R8: While any line is in service, irq_out is asserted only for pending lines of strictly higher priority than every in-service line. This applies across both stages.
- R9: An eoi pulse with eoi_num set to n removes line n from service. Lower-priority pending lines can then raise irq_out one edge later.
- R10: An acknowledge with no eligible pending line reports 7 and leaves the pending and in-service states unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_in | input | 16 | Asynchronous device request pins, one per line (pin 2 folds onto line 9) |
| ack | input | 1 | One-cycle acknowledge from the processor |
| eoi | input | 1 | One-cycle end-of-interrupt strobe |
| eoi_num | input | 4 | Line number taken out of service by eoi |
| irq_out | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | One-cycle strobe marking vec_num as fresh |
| vec_num | output | 4 | Number of the acknowledged line, or 7 if spurious |

## Verification
A request edge reaches irq_out on the fourth rising edge after the pin changes. The acknowledge result appears on the first edge after ack is sampled. The irq_out level that follows an acknowledge or an eoi settles one edge later again. Every bench task drives inputs just after a falling edge and counts exactly these edges before sampling on the next falling edge. A bench model of the pending and in-service sets, with the fixed rank order, predicts each vector number and irq_out level. A directed case samples irq_out one edge early, so the four-edge latency is checked from both sides.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int STAGE_LINES  = 8;
    localparam int TOTAL_LINES  = 2 * STAGE_LINES;
    localparam int NUM_W        = $clog2(TOTAL_LINES);
    localparam int STAGE_W      = $clog2(STAGE_LINES);
    localparam int CASC_POS     = 2;
    localparam int ALIAS_LINE   = STAGE_LINES + 1;
    localparam int SPURIOUS_NUM = 7;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_PEND   = 2'd1,
        S_REPORT = 2'd2
    } ctl_state_t;
endpackage

// File: rtl/irqc_edge_sync.sv
module irqc_edge_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] rise
);
    logic [WIDTH-1:0] chain [STAGES+1];

    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= din;
    end

    for (genvar g = 1; g <= STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain[g] <= '0;
            else        chain[g] <= chain[g-1];
        end
    end

    assign rise = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/irqc_resolve.sv
module irqc_resolve #(
    parameter int N        = 8,
    parameter bit CASC_EN  = 1'b0,
    parameter int CASC_POS = 2,
    localparam int IW      = $clog2(N)
) (
    input  logic [N-1:0]  pend,
    input  logic [N-1:0]  isr,
    input  logic          casc_req,
    output logic          req,
    output logic [IW-1:0] win
);
    logic blocked;

    always_comb begin
        req     = 1'b0;
        win     = '0;
        blocked = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (!req && !blocked) begin
                if (CASC_EN && i == CASC_POS) begin
                    if (casc_req) begin
                        req = 1'b1;
                        win = IW'(i);
                    end
                end else if (pend[i] && !isr[i]) begin
                    req = 1'b1;
                    win = IW'(i);
                end
            end
            blocked = blocked | isr[i];
        end
    end
endmodule

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [TOTAL_LINES-1:0] req_in,
    input  logic                   ack,
    input  logic                   eoi,
    input  logic [NUM_W-1:0]       eoi_num,
    output logic                   irq_out,
    output logic                   vec_valid,
    output logic [NUM_W-1:0]       vec_num
);
    ctl_state_t state, state_nx;

    logic [TOTAL_LINES-1:0] rise, set_pend, pend, isr;
    logic [TOTAL_LINES-1:0] clr_pend, clr_isr;
    logic [STAGE_LINES-1:0] pri_isr;
    logic                   s_req, p_req, grant;
    logic [STAGE_W-1:0]     s_win, p_win;
    logic [NUM_W-1:0]       win_num;

    irqc_edge_sync #(.WIDTH(TOTAL_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst_n (rst_n),
        .din (req_in),
        .rise (rise)
    );

    always_comb begin
        set_pend             = rise;
        set_pend[ALIAS_LINE] = rise[ALIAS_LINE] | rise[CASC_POS];
        set_pend[CASC_POS]   = 1'b0;
    end

    irqc_resolve #(.N(STAGE_LINES), .CASC_EN(1'b0), .CASC_POS(CASC_POS)) u_sec (
        .pend (pend[TOTAL_LINES-1:STAGE_LINES]),
        .isr (isr[TOTAL_LINES-1:STAGE_LINES]),
        .casc_req (1'b0),
        .req (s_req),
        .win (s_win)
    );

    always_comb begin
        pri_isr           = isr[STAGE_LINES-1:0];
        pri_isr[CASC_POS] = |isr[TOTAL_LINES-1:STAGE_LINES];
    end

    irqc_resolve #(.N(STAGE_LINES), .CASC_EN(1'b1), .CASC_POS(CASC_POS)) u_pri (
        .pend (pend[STAGE_LINES-1:0]),
        .isr (pri_isr),
        .casc_req (s_req),
        .req (p_req),
        .win (p_win)
    );

    assign win_num  = (int'(p_win) == CASC_POS) ? {1'b1, s_win} : {1'b0, p_win};
    assign grant    = ack & p_req;
    assign clr_pend = grant ? (TOTAL_LINES'(1) << win_num) : '0;
    assign clr_isr  = eoi ? (TOTAL_LINES'(1) << eoi_num) : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend    <= '0;
            isr     <= '0;
            vec_num <= '0;
        end else begin
            pend <= (pend & ~clr_pend) | set_pend;
            isr  <= (isr & ~clr_isr) | clr_pend;
            if (ack) vec_num <= p_req ? win_num : NUM_W'(SPURIOUS_NUM);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (ack) state_nx = S_REPORT;
                      else if (p_req) state_nx = S_PEND;
            S_PEND:   if (ack) state_nx = S_REPORT;
                      else if (!p_req) state_nx = S_IDLE;
            S_REPORT: if (ack) state_nx = S_REPORT;
                      else state_nx = p_req ? S_PEND : S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    always_comb begin
        irq_out   = (state == S_PEND);
        vec_valid = (state == S_REPORT);
    end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ack,
    input logic       irq_out,
    input logic       vec_valid,
    input logic [3:0] vec_num
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!irq_out && !vec_valid));

    p_ack_reports_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> vec_valid);

    p_report_from_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(ack));

    p_irq_low_in_report_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> !irq_out);

    p_vec_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |=> $stable(vec_num));

    p_never_two_r3: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (vec_num != 4'd2));
endmodule

bind cascade_irq_ctrl irqc_checker u_chk (
    .clk (clk),
    .rst_n (rst_n),
    .ack (ack),
    .irq_out (irq_out),
    .vec_valid (vec_valid),
    .vec_num (vec_num)
);

// File: tb/sim_cascade_irq_ctrl.sv
`timescale 1ns/1ps
module sim_cascade_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] req_in = '0;
    logic        ack = 1'b0;
    logic        eoi = 1'b0;
    logic [3:0]  eoi_num = '0;
    logic        irq_out, vec_valid;
    logic [3:0]  vec_num;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [15:0] pend_m = '0;
    logic [15:0] isr_m = '0;

    always #10 clk = ~clk;

    cascade_irq_ctrl u0 (
        .clk (clk),
        .rst_n (rst_n),
        .req_in (req_in),
        .ack (ack),
        .eoi (eoi),
        .eoi_num (eoi_num),
        .irq_out (irq_out),
        .vec_valid (vec_valid),
        .vec_num (vec_num)
    );

    task automatic chk(string r, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
        end
    endtask

    function automatic int rank(int n);
        if (n < 2) return n;
        if (n >= 8) return n - 6;
        return n + 7;
    endfunction

    function automatic int cand();
        int best = -1;
        int floor_r = 16;
        for (int n = 0; n < 16; n++)
            if (isr_m[n] && rank(n) < floor_r) floor_r = rank(n);
        for (int n = 0; n < 16; n++)
            if (pend_m[n] && rank(n) < floor_r && (best < 0 || rank(n) < rank(best)))
                best = n;
        return best;
    endfunction

    task automatic pulse(logic [15:0] mask, string r);
        logic [15:0] m = mask;
        if (m[2]) m[9] = 1'b1;
        m[2] = 1'b0;
        @(negedge clk) req_in = mask;
        @(negedge clk) req_in = '0;
        repeat (3) @(negedge clk);
        pend_m |= m;
        chk({r, " irq after request"}, int'(irq_out), int'(cand() >= 0));
    endtask

    task automatic do_ack(string r, int want);
        int exp = cand();
        @(negedge clk) ack = 1'b1;
        @(negedge clk) ack = 1'b0;
        chk("R6 vec_valid", int'(vec_valid), 1);
        chk("R6 irq low in report", int'(irq_out), 0);
        chk({r, " vec_num"}, int'(vec_num), (exp < 0) ? 7 : exp);
        if (want >= 0) chk({r, " directed vec_num"}, int'(vec_num), want);
        if (exp >= 0) begin
            pend_m[exp] = 1'b0;
            isr_m[exp] = 1'b1;
        end
        @(negedge clk);
        chk("R6 vec_valid one cycle", int'(vec_valid), 0);
        chk("R7 irq after ack", int'(irq_out), int'(cand() >= 0));
    endtask

    task automatic do_eoi(int num);
        @(negedge clk) begin eoi = 1'b1; eoi_num = 4'(num); end
        @(negedge clk) eoi = 1'b0;
        isr_m[num] = 1'b0;
        @(negedge clk);
        chk("R9 irq after eoi", int'(irq_out), int'(cand() >= 0));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog all-R actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1 irq in reset", int'(irq_out), 0);
        chk("R1 valid in reset", int'(vec_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irq after reset", int'(irq_out), 0);
        do_ack("R1 R10 spurious", 7);

        // R2: held level, exact latency, no retrigger
        @(negedge clk) req_in = 16'h0020;
        repeat (3) @(negedge clk);
        chk("R2 irq not before fourth edge", int'(irq_out), 0);
        @(negedge clk);
        chk("R2 irq at fourth edge", int'(irq_out), 1);
        pend_m[5] = 1'b1;
        do_ack("R2", 5);
        repeat (4) @(negedge clk);
        chk("R2 held level no retrigger", int'(irq_out), 0);
        req_in = '0;
        do_eoi(5);
        chk("R2 no second latch", int'(irq_out), 0);

        // R3 alias, R4 fixed lines
        pulse(16'h0004, "R3");
        do_ack("R3 alias", 9);
        do_eoi(9);
        pulse(16'h0001, "R4");
        do_ack("R4 line0", 0);
        do_eoi(0);
        pulse(16'h0002, "R4");
        do_ack("R4 line1", 1);
        do_eoi(1);
        pulse(16'h0100, "R4");
        do_ack("R4 line8", 8);
        do_eoi(8);

        // R5 / R8 ordering and nesting
        pulse(16'h9088, "R5");
        do_ack("R5 first", 12);
        chk("R8 lower blocked", int'(irq_out), 0);
        pulse(16'h0002, "R8");
        chk("R8 higher nests", int'(irq_out), 1);
        do_ack("R8 nested", 1);
        do_eoi(1);
        do_eoi(12);
        do_ack("R5 second", 15);
        do_eoi(15);
        do_ack("R5 third", 3);
        do_eoi(3);
        do_ack("R5 fourth", 7);
        do_eoi(7);

        // R10 blocked pending yields spurious, state unchanged
        pulse(16'h0001, "R10");
        do_ack("R10 setup", 0);
        pulse(16'h0020, "R10");
        chk("R10 blocked irq low", int'(irq_out), 0);
        do_ack("R10 spurious", 7);
        do_eoi(0);
        chk("R10 pending kept", int'(irq_out), 1);
        do_ack("R10 kept line", 5);
        do_eoi(5);

        // random mix
        for (int it = 0; it < 400; it++) begin
            int op = int'($urandom_range(0, 2));
            if (op == 0) pulse(16'($urandom & $urandom & $urandom), "R5 R2 random");
            else if (op == 1) do_ack("R5 R7 random", -1);
            else do_eoi(int'($urandom_range(0, 15)));
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule